// File: doc/BRIEF.md
# Sweep Oscillator Core with Sine/Triangle Shaping

This block is a numerically controlled oscillator for a frequency-sweep generator. Each master clock it adds a 24-bit tuning word to a phase register. It turns the upper phase bits into a 10-bit offset-binary sample, either a sine wave or a linear up-down ramp. A sweep sequencer drives the tuning word and changes it step by step. The phase register is never cleared on a step, so the waveform stays continuous across every frequency change. A separate restart strobe sets the phase to zero at the start of a sweep.

The block also exports the inverted most significant bit of the sample as a square wave, with its own output-enable for a three-state pad. A one-cycle pulse marks each phase-register overflow. A standby input freezes the oscillator at its current point, and it resumes from there when standby is released. Until the first restart, and whenever the sample output is disabled, the sample rests at midscale (512).

Top module: `sweep_nco`

## Requirements
- R1: At each rising clock edge while running and not in standby, the phase register P advances by the tuning word, modulo 2^24. The sample captured at that edge is computed from P before the addition, so the k-th sample after a restart reflects phase (k-1)·word.
- R2: A restart pulse clears P to zero and starts the oscillator. In the cycle after the restart edge, sampleOut is 512. In the cycle after that, it shows the zero-phase value: 512 for sine, 0 for triangle.
- R3: A change of the tuning word without a restart continues from the present phase. The next phase is the old phase plus the new word.
- R4: In sine mode, the 12-bit truncated phase T = P[23:12] gives a sample within 3 LSB of 511.5 + 511·sin(2π(T+0.5)/4096). Samples for T < 2048 are at least 512, and samples for T ≥ 2048 are at most 511.
- R5: In triangle mode, with U = P[23:13] (11 bits), the sample is U[9:0] when U[10] = 0 and 1023 − U[9:0] when U[10] = 1.
- R6: squareOut is the inverse of bit 9 of the registered sample, regardless of dacEn. squareOe equals msbEn.
- R7: While dacEn is 0, sampleOut is 512. The oscillator and squareOut keep running.
- R8: While standby is 1 and no restart is applied, P and the registered sample do not change, and wrapPulse is 0. After standby is released, advancing resumes from the held phase.
- R9: After reset, and until the first restart, sampleOut is 512, squareOut is 0 and wrapPulse is 0, whatever the tuning word.
- R10: wrapPulse is 1 for exactly the cycle that follows an edge at which the 24-bit addition carried out, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freqWord | input | 24 | Tuning word added to the phase each cycle |
| phaseRestart | input | 1 | Clears phase to zero and starts the oscillator |
| sineSel | input | 1 | 1 selects sine shaping, 0 selects triangle |
| dacEn | input | 1 | 1 passes the sample out, 0 forces midscale |
| msbEn | input | 1 | Enable for the square-wave pad driver |
| standby | input | 1 | Freezes phase and held sample |
| sampleOut | output | 10 | Offset-binary waveform sample |
| squareOut | output | 1 | Inverted sample MSB |
| squareOe | output | 1 | Output enable for squareOut |
| wrapPulse | output | 1 | One-cycle phase overflow marker |

## Verification
The hardest condition to reach from the ports is seeing every entry of the quarter-wave table through all four mirrored quadrants, together with every triangle code. With an arbitrary tuning word, the truncated phase jumps and skips codes. The stimulus therefore restarts at zero phase and uses a tuning word of exactly one truncated-phase step (2^12 for sine, 2^13 for triangle), so that each 12-bit or 11-bit phase code appears in turn once per period. Phase continuity and freezing are then driven by changing the word and toggling standby in the middle of a run, with no restart.

// File: rtl/sweep_nco_pkg.sv
package sweep_nco_pkg;

  typedef struct packed {
    logic clearPhase;
    logic advance;
    logic loadMid;
  } ncoCtl_t;

  // Quarter-wave magnitude for entry idx of a table with 2**addrW entries,
  // peak (2**(ampW-1))-1, sampled at half-step offsets; integer rational
  // sine approximation evaluated at elaboration.
  function automatic int quarterMag(input int idx, input int addrW, input int ampW);
    longint halfSteps;
    longint pos;
    longint prod;
    longint peak;
    longint num;
    longint den;
    begin
      halfSteps = longint'(4) << addrW;
      pos       = 2 * longint'(idx) + 1;
      prod      = pos * (halfSteps - pos);
      peak      = (longint'(1) << (ampW - 1)) - 1;
      num       = 16 * prod * peak;
      den       = 5 * halfSteps * halfSteps - 4 * prod;
      quarterMag = int'(num / den);
    end
  endfunction

endpackage

// File: rtl/sweep_nco_qrom.sv
module sweep_nco_qrom #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [AMP_W-2:0]   mag
);
  import sweep_nco_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAG_W = AMP_W - 1;

  logic [MAG_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    assign table_q[g] = MAG_W'(quarterMag(g, ADDR_W, AMP_W));
  end

  assign mag = table_q[addr];

endmodule

// File: rtl/sweep_nco_ctrl.sv
module sweep_nco_ctrl
  import sweep_nco_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    phaseRestart,
  input  logic    standby,
  output ncoCtl_t ctl
);

  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else if (phaseRestart) running <= 1'b1;
  end

  always_comb begin
    ctl.clearPhase = phaseRestart;
    ctl.advance    = running && !standby && !phaseRestart;
    ctl.loadMid    = phaseRestart || !running;
  end

endmodule

// File: rtl/sweep_nco_datapath.sv
module sweep_nco_datapath
  import sweep_nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10,
  parameter int QADDR_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ncoCtl_t            ctl,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               sineSel,
  input  logic               dacEn,
  input  logic               msbEn,
  output logic [AMP_W-1:0]   sampleOut,
  output logic               squareOut,
  output logic               squareOe,
  output logic               wrapPulse
);

  localparam int TRUNC_W = QADDR_W + 2;
  localparam int TRI_W   = AMP_W + 1;
  localparam int MAG_W   = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W:0]   phaseSum;
  logic [AMP_W-1:0]   sampleReg;
  logic               wrapReg;

  logic [TRUNC_W-1:0] truncPhase;
  logic [QADDR_W-1:0] romAddr;
  logic [MAG_W-1:0]   romMag;
  logic [AMP_W-1:0]   sineVal;
  logic [TRI_W-1:0]   triPhase;
  logic [AMP_W-1:0]   triVal;
  logic [AMP_W-1:0]   waveNext;

  assign phaseSum = {1'b0, phaseAcc} + {1'b0, freqWord};

  // Sine: quadrant bit mirrors the address, sign bit folds the amplitude.
  assign truncPhase = phaseAcc[PHASE_W-1 -: TRUNC_W];
  assign romAddr    = truncPhase[QADDR_W] ? ~truncPhase[QADDR_W-1:0]
                                          : truncPhase[QADDR_W-1:0];

  sweep_nco_qrom #(.ADDR_W(QADDR_W), .AMP_W(AMP_W)) u_qrom (
    .addr (romAddr),
    .mag  (romMag)
  );

  assign sineVal = truncPhase[QADDR_W+1] ? (MID - AMP_W'(1) - {1'b0, romMag})
                                         : (MID + {1'b0, romMag});

  // Triangle: top bit selects the falling half by inversion.
  assign triPhase = phaseAcc[PHASE_W-1 -: TRI_W];
  assign triVal   = triPhase[AMP_W] ? ~triPhase[AMP_W-1:0] : triPhase[AMP_W-1:0];

  assign waveNext = sineSel ? sineVal : triVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      sampleReg <= MID;
      wrapReg   <= 1'b0;
    end else begin
      wrapReg <= 1'b0;
      if (ctl.clearPhase) begin
        phaseAcc <= '0;
      end else if (ctl.advance) begin
        phaseAcc <= phaseSum[PHASE_W-1:0];
        wrapReg  <= phaseSum[PHASE_W];
      end
      if (ctl.loadMid) sampleReg <= MID;
      else if (ctl.advance) sampleReg <= waveNext;
    end
  end

  assign sampleOut = dacEn ? sampleReg : MID;
  assign squareOut = ~sampleReg[AMP_W-1];
  assign squareOe  = msbEn;
  assign wrapPulse = wrapReg;

endmodule

// File: rtl/sweep_nco.sv
module sweep_nco
  import sweep_nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10,
  parameter int QADDR_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               phaseRestart,
  input  logic               sineSel,
  input  logic               dacEn,
  input  logic               msbEn,
  input  logic               standby,
  output logic [AMP_W-1:0]   sampleOut,
  output logic               squareOut,
  output logic               squareOe,
  output logic               wrapPulse
);

  ncoCtl_t ctl;

  sweep_nco_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .phaseRestart (phaseRestart),
    .standby      (standby),
    .ctl          (ctl)
  );

  sweep_nco_datapath #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W),
    .QADDR_W (QADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .freqWord  (freqWord),
    .sineSel   (sineSel),
    .dacEn     (dacEn),
    .msbEn     (msbEn),
    .sampleOut (sampleOut),
    .squareOut (squareOut),
    .squareOe  (squareOe),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: rtl/sweep_nco_chk.sv
module sweep_nco_chk #(
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             phaseRestart,
  input logic             dacEn,
  input logic             standby,
  input logic [AMP_W-1:0] sampleOut,
  input logic             squareOut,
  input logic             wrapPulse
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  AST_RESTART_MID: assert property (@(posedge clk) disable iff (!rstN)
    phaseRestart |=> (sampleOut == MID));  // R2

  AST_DAC_OFF_MID: assert property (@(posedge clk) disable iff (!rstN)
    !dacEn |-> (sampleOut == MID));  // R7

  AST_SQUARE_INV: assert property (@(posedge clk) disable iff (!rstN)
    dacEn |-> (squareOut == !sampleOut[AMP_W-1]));  // R6

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !phaseRestart) |=> ($stable(squareOut) && !wrapPulse));  // R8

  AST_WRAP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> $past(!standby && !phaseRestart));  // R10

endmodule

bind sweep_nco sweep_nco_chk #(.AMP_W(AMP_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .phaseRestart (phaseRestart),
  .dacEn        (dacEn),
  .standby      (standby),
  .sampleOut    (sampleOut),
  .squareOut    (squareOut),
  .wrapPulse    (wrapPulse)
);

// File: tb/sweep_nco_tb.sv
module sweep_nco_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] freqWord = 24'h012345;
  logic        phaseRestart = 1'b0;
  logic        sineSel = 1'b1;
  logic        dacEn = 1'b1;
  logic        msbEn = 1'b1;
  logic        standby = 1'b0;
  logic [9:0]  sampleOut;
  logic        squareOut;
  logic        squareOe;
  logic        wrapPulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sweep_nco u_dut (
    .clk (clk), .rstN (rstN), .freqWord (freqWord), .phaseRestart (phaseRestart),
    .sineSel (sineSel), .dacEn (dacEn), .msbEn (msbEn), .standby (standby),
    .sampleOut (sampleOut), .squareOut (squareOut), .squareOe (squareOe),
    .wrapPulse (wrapPulse)
  );

  // Requirement-level model: running flag, phase, phase of held sample.
  logic        mRun = 1'b0;
  logic [23:0] mAcc = '0;
  logic        mValid = 1'b0;
  logic [23:0] mOutPhase = '0;
  logic        mOutSine = 1'b0;
  logic        mWrap = 1'b0;

  always @(posedge clk or negedge rstN) begin
    logic [24:0] s;
    if (!rstN) begin
      mRun = 0; mAcc = 0; mValid = 0; mWrap = 0;
    end else begin
      cycles++;
      mWrap = 0;
      if (phaseRestart) begin
        mRun = 1; mAcc = 0; mValid = 0;
      end else if (mRun && !standby) begin
        mOutPhase = mAcc; mOutSine = sineSel; mValid = 1;
        s = {1'b0, mAcc} + {1'b0, freqWord};
        mAcc = s[23:0]; mWrap = s[24];
      end
    end
  end

  task automatic report(input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  task automatic cmp(input string tag);
    int raw;
    int expSq;
    real theta;
    real ideal;
    real diff;
    int t12;
    int u11;
    int lo;
    expSq = 0;
    if (!mValid) begin
      raw = 512;
      expSq = 0;
      report(tag, "sample", int'(sampleOut), 512);
    end else if (mOutSine) begin
      t12 = int'(mOutPhase[23:12]);
      expSq = (t12 >= 2048) ? 1 : 0;
      if (dacEn) begin
        theta = 2.0 * 3.14159265358979 * (real'(t12) + 0.5) / 4096.0;
        ideal = 511.5 + 511.0 * $sin(theta);
        diff = real'(sampleOut) - ideal;
        if (diff < 0.0) diff = -diff;
        checks++;
        if (diff > 3.0) begin
          failures++;
          $display("FAIL %s sine actual=%0d expected=%0d", tag, sampleOut, int'(ideal));
        end
        report(tag, "sine half", int'(sampleOut[9]), 1 - expSq);
      end else begin
        report(tag, "sample", int'(sampleOut), 512);
      end
    end else begin
      u11 = int'(mOutPhase[23:13]);
      lo = u11 & 1023;
      raw = (u11 >= 1024) ? (1023 - lo) : lo;
      expSq = (raw >= 512) ? 0 : 1;
      report(tag, "sample", int'(sampleOut), dacEn ? raw : 512);
    end
    report("R6", "square", int'(squareOut), expSq);
    report("R6", "oe", int'(squareOe), int'(msbEn));
    report("R10", "wrap", int'(wrapPulse), int'(mWrap));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic restart(input string tag);
    phaseRestart = 1'b1;
    run(1, tag);
    phaseRestart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    report("R9", "reset sample", int'(sampleOut), 512);
    report("R9", "reset square", int'(squareOut), 0);
    report("R9", "reset wrap", int'(wrapPulse), 0);
    rstN = 1'b1;
    run(8, "R9");

    // R2 and R5: one triangle code per cycle over a full period.
    sineSel = 1'b0;
    freqWord = 24'd1 << 13;
    restart("R2");
    run(1, "R2");
    report("R2", "zero-phase triangle", int'(sampleOut), 0);
    run(2050, "R5");

    // R2 and R4: one sine code per cycle over a full period.
    sineSel = 1'b1;
    freqWord = 24'd1 << 12;
    restart("R2");
    run(1, "R2");
    report("R2", "zero-phase sine", int'(sampleOut), 512);
    run(4100, "R4");

    // R1: arbitrary tuning words.
    freqWord = 24'h0A3D71;
    restart("R2");
    run(1500, "R1");
    sineSel = 1'b0;
    run(500, "R1");

    // R3: word changes with no restart.
    for (int i = 0; i < 20; i++) begin
      freqWord = 24'(24'h1000 * (i + 1) + i * 333);
      sineSel = i[0];
      run(37, "R3");
    end

    // R10: overflow-heavy words and a zero word.
    freqWord = 24'hFFF000;
    run(300, "R10");
    freqWord = 24'h800000;
    run(50, "R10");
    freqWord = 24'h000000;
    run(20, "R10");

    // R6: output enable toggling.
    freqWord = 24'h030000;
    for (int i = 0; i < 40; i++) begin
      msbEn = i[0];
      sineSel = i[1];
      run(7, "R6");
    end
    msbEn = 1'b1;

    // R7: sample gating while the oscillator keeps running.
    for (int i = 0; i < 40; i++) begin
      dacEn = i[0];
      sineSel = i[1];
      run(7, "R7");
    end
    dacEn = 1'b1;

    // R8: freeze and resume.
    freqWord = 24'h0C1234;
    for (int i = 0; i < 20; i++) begin
      standby = 1'b1;
      run(5, "R8");
      standby = 1'b0;
      run(3, "R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule